// File: doc/BRIEF.md
# Byte-Laned DRAM Pin Responder

This block stands in for a small 16-bit dynamic memory on a synthesizable test platform, so that a memory controller can be exercised without an external behavioural model. It samples the row strobe, the two byte column strobes, write enable, output enable, the 9-bit multiplexed address and the write data on a fast reference clock. Strobe edges are found by comparing consecutive samples. The row is captured when the row strobe falls and the column when the first column strobe falls. Data lives in a reduced array that keeps only the low row and column address bits.

Each byte lane has its own drive enable. A lane starts to drive only when its own column strobe is low during a read. Its data stays on the pins after that strobe rises, in the extended-data-out manner. If a column strobe is already low when the row strobe falls, the cycle is a refresh driven by an internal row counter. That counter is visible as an output. Four sticky flags record too-short strobe intervals, measured in reference-clock samples.

A pin change becomes visible at the outputs two reference-clock edges later: one edge to sample the pin and one to register the output.

Top module: `dram_pin_responder`

## Requirements
- R1: While the row strobe is high and both column strobes are high, both lanes are undriven (`dq_oe` = 0).
- R2: With the row strobe low, write enable high and output enable low, each lane whose column strobe is low drives the stored byte at the latched row and column. Lane 0 (`dq_out[7:0]`) follows `lcas_n` and lane 1 (`dq_out[15:8]`) follows `ucas_n`. A lane whose strobe is high stays undriven.
- R3: With the row strobe low, write enable low and output enable high, each lane whose column strobe is low stores its byte of `dq_in`. The byte of the other lane in memory keeps its old value.
- R4: Both column strobes low with write enable and output enable both high neither drives nor writes.
- R5: A driving lane keeps driving the same data after its column strobe rises, as long as the row strobe stays low.
- R6: A driving lane turns off when output enable goes high, when write enable goes low, or when the row strobe and both column strobes are all high.
- R7: A row strobe low period in which both column strobes stay high drives nothing and leaves the stored data unchanged.
- R8: If a column strobe is low in the sample before the row strobe falls, the cycle is a refresh. It makes no access, and `rfsh_row` increases by one, wrapping modulo 2^ROW_BITS.
- R9: Only the low ROW_BITS row address bits and the low COL_BITS column address bits select a word. Addresses that differ only in higher bits refer to the same word.
- R10: `timing_err` bits are sticky and are measured in samples. Bit 0 is set when the row strobe is low for fewer than MIN_RAS samples. Bit 1 is set when it is high for fewer than MIN_RP samples. Bit 2 is set when, with the row strobe low and after the first column access of that row, both column strobes are high for fewer than MIN_CP samples. Bit 3 is set when the first column strobe fall comes fewer than MIN_RCD samples after the row strobe fall.
- R11: After reset, `dq_oe`, `rfsh_row` and `timing_err` are all zero.
- R12: The column is captured when the column strobes leave the both-high state. A later fall of both strobes within the same row strobe low period captures a new column (page mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Column strobe for lane 0, active low |
| ucas_n | input | 1 | Column strobe for lane 1, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_PINS | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the controller |
| dq_out | output | 16 | Read data toward the controller |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 for the low byte |
| rfsh_row | output | ROW_BITS | Internal refresh row counter |
| timing_err | output | 4 | Sticky timing violation flags |

## Verification
A wrong latched row or column shows up at the first read of that word as a wrong byte on a driven lane, two edges after the column strobe falls. A stuck or mistimed lane-enable register shows up within two edges of the strobe change, as a lane that drives with its strobe high or that keeps driving after output enable rises. A faulty refresh-cycle decision shows up in one of two ways: a counter that does not advance, or a stored word that a following read finds altered. A miscounted interval shows up as a flag set after a legal sequence, or left clear after a short one.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ERR_W  = 4;

  // timing flag positions
  localparam int unsigned ERR_RAS = 0;
  localparam int unsigned ERR_RP  = 1;
  localparam int unsigned ERR_CP  = 2;
  localparam int unsigned ERR_RCD = 3;

  typedef struct packed {
    logic             ras_n;
    logic [LANES-1:0] cas_n;  // [0] low byte, [1] high byte
    logic             we_n;
    logic             oe_n;
  } strobe_t;
endpackage

// File: rtl/dpr_sampler.sv
module dpr_sampler
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           pin_stb,
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic [DATA_W-1:0] pin_dq,
  output strobe_t           cur_stb,
  output strobe_t           prv_stb,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_dq
);
  strobe_t           cur_q, prv_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '1;
      prv_q  <= '1;
      addr_q <= '0;
      dq_q   <= '0;
    end else begin
      cur_q  <= pin_stb;
      prv_q  <= cur_q;
      addr_q <= pin_addr;
      dq_q   <= pin_dq;
    end
  end

  assign cur_stb  = cur_q;
  assign prv_stb  = prv_q;
  assign cur_addr = addr_q;
  assign cur_dq   = dq_q;
endmodule

// File: rtl/dpr_timing.sv
module dpr_timing
  import dpr_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MIN_RAS = 4,
  parameter int unsigned MIN_RP  = 3,
  parameter int unsigned MIN_CP  = 2,
  parameter int unsigned MIN_RCD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_low,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_all_hi,
  input  logic             cas_fall,
  input  logic             cbr_start,
  output logic [ERR_W-1:0] err
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LIM_RAS  = CNT_W'(MIN_RAS);
  localparam logic [CNT_W-1:0] LIM_RP   = CNT_W'(MIN_RP);
  localparam logic [CNT_W-1:0] LIM_CP   = CNT_W'(MIN_CP);
  localparam logic [CNT_W-1:0] LIM_RCD  = CNT_W'(MIN_RCD);

  logic [CNT_W-1:0] ras_run_q, ras_run_d;
  logic [CNT_W-1:0] cp_run_q,  cp_run_d;
  logic [CNT_W-1:0] rcd_run_q, rcd_run_d;
  logic             first_q,   first_d;
  logic [ERR_W-1:0] err_q,     err_d;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_comb begin
    ras_run_d = (ras_fall || ras_rise) ? CNT_W'(1) : sat_inc(ras_run_q);
    cp_run_d  = cas_all_hi ? sat_inc(cp_run_q) : '0;
    rcd_run_d = ras_fall ? CNT_W'(1) : sat_inc(rcd_run_q);

    first_d = first_q;
    if (ras_fall)                  first_d = !cbr_start;
    else if (cas_fall || ras_rise) first_d = 1'b0;

    err_d = err_q;
    if (ras_rise && ras_run_q < LIM_RAS) err_d[ERR_RAS] = 1'b1;
    if (ras_fall && ras_run_q < LIM_RP)  err_d[ERR_RP]  = 1'b1;
    if (cas_fall && ras_low && !first_q && cp_run_q < LIM_CP)
      err_d[ERR_CP] = 1'b1;
    if (cas_fall && ras_low && first_q && rcd_run_q < LIM_RCD)
      err_d[ERR_RCD] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_run_q <= CNT_MAX;
      cp_run_q  <= CNT_MAX;
      rcd_run_q <= CNT_MAX;
      first_q   <= 1'b0;
      err_q     <= '0;
    end else begin
      ras_run_q <= ras_run_d;
      cp_run_q  <= cp_run_d;
      rcd_run_q <= rcd_run_d;
      first_q   <= first_d;
      err_q     <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/dpr_array.sv
module dpr_array
  import dpr_pkg::*;
#(
  parameter int unsigned ROW_BITS = 4,
  parameter int unsigned COL_BITS = 4
) (
  input  logic                          clk,
  input  logic [ROW_BITS+COL_BITS-1:0]  idx,
  input  logic [LANES-1:0]              wr_be,
  input  logic [LANES*BYTE_W-1:0]       wdata,
  output logic [LANES*BYTE_W-1:0]       rdata
);
  localparam int unsigned IDX_W = ROW_BITS + COL_BITS;
  localparam int unsigned DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_mem
    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_be[g]) cells[idx] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = cells[idx];
  end
endmodule

// File: rtl/dpr_lane.sv
module dpr_lane
  import dpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drop,
  input  logic [BYTE_W-1:0] rbyte,
  output logic              drive,
  output logic [BYTE_W-1:0] q
);
  logic              drive_q, drive_d;
  logic [BYTE_W-1:0] data_q,  data_d;
  logic              upd_en;

  always_comb begin
    upd_en  = load || drop;
    drive_d = drive_q;
    data_d  = data_q;
    if (load) begin
      drive_d = 1'b1;
      data_d  = rbyte;
    end else if (drop) begin
      drive_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      data_q  <= '0;
    end else if (upd_en) begin
      drive_q <= drive_d;
      data_q  <= data_d;
    end
  end

  assign drive = drive_q;
  assign q     = data_q;
endmodule

// File: rtl/dram_pin_responder.sv
module dram_pin_responder
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_PINS = 9,
  parameter int unsigned ROW_BITS  = 4,
  parameter int unsigned COL_BITS  = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MIN_RAS   = 4,
  parameter int unsigned MIN_RP    = 3,
  parameter int unsigned MIN_CP    = 2,
  parameter int unsigned MIN_RCD   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ras_n,
  input  logic                      lcas_n,
  input  logic                      ucas_n,
  input  logic                      we_n,
  input  logic                      oe_n,
  input  logic [ADDR_PINS-1:0]      addr,
  input  logic [LANES*BYTE_W-1:0]   dq_in,
  output logic [LANES*BYTE_W-1:0]   dq_out,
  output logic [LANES-1:0]          dq_oe,
  output logic [ROW_BITS-1:0]       rfsh_row,
  output logic [ERR_W-1:0]          timing_err
);
  localparam int unsigned DATA_W = LANES * BYTE_W;
  localparam int unsigned IDX_W  = ROW_BITS + COL_BITS;

  // reset: asserted at once, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // pin sampling
  strobe_t                pin_stb, s_stb, p_stb;
  logic [ADDR_PINS-1:0]   s_addr;
  logic [DATA_W-1:0]      s_dq;

  always_comb begin
    pin_stb.ras_n    = ras_n;
    pin_stb.cas_n[0] = lcas_n;
    pin_stb.cas_n[1] = ucas_n;
    pin_stb.we_n     = we_n;
    pin_stb.oe_n     = oe_n;
  end

  dpr_sampler #(.ADDR_W(ADDR_PINS), .DATA_W(DATA_W)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_q),
    .pin_stb  (pin_stb),
    .pin_addr (addr),
    .pin_dq   (dq_in),
    .cur_stb  (s_stb),
    .prv_stb  (p_stb),
    .cur_addr (s_addr),
    .cur_dq   (s_dq)
  );

  // edge detection
  logic ras_fall, ras_rise, cas_all_hi, cas_was_hi, cas_fall, cas_pre_low;
  always_comb begin
    ras_fall    = p_stb.ras_n && !s_stb.ras_n;
    ras_rise    = !p_stb.ras_n && s_stb.ras_n;
    cas_all_hi  = &s_stb.cas_n;
    cas_was_hi  = &p_stb.cas_n;
    cas_fall    = cas_was_hi && !cas_all_hi;
    cas_pre_low = !cas_was_hi;
  end

  // cycle state
  logic [ROW_BITS-1:0] row_q,  row_d;
  logic [COL_BITS-1:0] col_q,  col_d;
  logic                cbr_q,  cbr_d;
  logic [ROW_BITS-1:0] rfsh_q, rfsh_d;
  logic                row_en, col_en, cbr_en, rfsh_en;

  logic                cbr_start, cbr_eff, acc_ok, rd_en, off_req;
  logic [ROW_BITS-1:0] row_eff;
  logic [COL_BITS-1:0] col_eff;
  logic [IDX_W-1:0]    cell_idx;
  logic [LANES-1:0]    wr_be, rd_load;

  always_comb begin
    cbr_start = ras_fall && cas_pre_low;
    cbr_eff   = ras_fall ? cas_pre_low : cbr_q;
    row_eff   = ras_fall ? s_addr[ROW_BITS-1:0] : row_q;
    col_eff   = cas_fall ? s_addr[COL_BITS-1:0] : col_q;
    cell_idx  = {row_eff, col_eff};

    acc_ok  = !s_stb.ras_n && !cbr_eff;
    rd_en   = acc_ok && s_stb.we_n && !s_stb.oe_n;
    off_req = (s_stb.ras_n && cas_all_hi) || s_stb.oe_n || !s_stb.we_n;

    for (int i = 0; i < LANES; i++) begin
      wr_be[i]   = acc_ok && !s_stb.we_n && s_stb.oe_n && !s_stb.cas_n[i];
      rd_load[i] = rd_en && !s_stb.cas_n[i];
    end

    row_en  = ras_fall && !cas_pre_low;
    row_d   = s_addr[ROW_BITS-1:0];
    col_en  = cas_fall && !s_stb.ras_n;
    col_d   = s_addr[COL_BITS-1:0];
    cbr_en  = ras_fall || ras_rise;
    cbr_d   = cbr_start;
    rfsh_en = cbr_start;
    rfsh_d  = rfsh_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      row_q  <= '0;
      col_q  <= '0;
      cbr_q  <= 1'b0;
      rfsh_q <= '0;
    end else begin
      if (row_en)  row_q  <= row_d;
      if (col_en)  col_q  <= col_d;
      if (cbr_en)  cbr_q  <= cbr_d;
      if (rfsh_en) rfsh_q <= rfsh_d;
    end
  end

  // storage
  logic [DATA_W-1:0] rd_word;
  dpr_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
    .clk   (clk),
    .idx   (cell_idx),
    .wr_be (wr_be),
    .wdata (s_dq),
    .rdata (rd_word)
  );

  // per-lane output holding
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpr_lane u_lane (
      .clk   (clk),
      .rst_n (rst_q),
      .load  (rd_load[g]),
      .drop  (off_req),
      .rbyte (rd_word[g*BYTE_W +: BYTE_W]),
      .drive (dq_oe[g]),
      .q     (dq_out[g*BYTE_W +: BYTE_W])
    );
  end

  // interval checking
  dpr_timing #(
    .CNT_W   (CNT_W),
    .MIN_RAS (MIN_RAS),
    .MIN_RP  (MIN_RP),
    .MIN_CP  (MIN_CP),
    .MIN_RCD (MIN_RCD)
  ) u_timing (
    .clk        (clk),
    .rst_n      (rst_q),
    .ras_low    (!s_stb.ras_n),
    .ras_fall   (ras_fall),
    .ras_rise   (ras_rise),
    .cas_all_hi (cas_all_hi),
    .cas_fall   (cas_fall),
    .cbr_start  (cbr_start),
    .err        (timing_err)
  );

  assign rfsh_row = rfsh_q;
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int unsigned ROW_BITS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ras_n,
  input logic                lcas_n,
  input logic                ucas_n,
  input logic                we_n,
  input logic                oe_n,
  input logic [1:0]          dq_oe,
  input logic [ROW_BITS-1:0] rfsh_row,
  input logic [3:0]          timing_err
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R1
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
    ($past(ras_n, 2) && $past(lcas_n, 2) && $past(ucas_n, 2)) |-> (dq_oe == 2'b00));

  // R2
  low_lane_start_chk: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
    $rose(dq_oe[0]) |-> (!$past(lcas_n, 2) && !$past(ras_n, 2) && $past(we_n, 2) && !$past(oe_n, 2)));

  // R2
  high_lane_start_chk: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
    $rose(dq_oe[1]) |-> (!$past(ucas_n, 2) && !$past(ras_n, 2) && $past(we_n, 2) && !$past(oe_n, 2)));

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
    $past(oe_n, 2) |-> (dq_oe == 2'b00));

  // R6
  we_off_chk: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
    !$past(we_n, 2) |-> (dq_oe == 2'b00));

  // R8
  rfsh_step_chk: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
    (rfsh_row == $past(rfsh_row)) || (rfsh_row == ROW_BITS'($past(rfsh_row) + 1'b1)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
    ((timing_err & $past(timing_err)) == $past(timing_err)));
endmodule

bind dram_pin_responder dpr_checker #(.ROW_BITS(ROW_BITS)) u_dpr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (ras_n),
  .lcas_n     (lcas_n),
  .ucas_n     (ucas_n),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .dq_oe      (dq_oe),
  .rfsh_row   (rfsh_row),
  .timing_err (timing_err)
);

// File: tb/dram_pin_responder_bench.sv
module dram_pin_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RB   = 4;
  localparam int CB   = 4;
  localparam int NW   = 1 << (RB + CB);
  localparam int NRND = 40;

  logic        clk, rst_n;
  logic        ras_n, lcas_n, ucas_n, we_n, oe_n;
  logic [8:0]  addr;
  logic [15:0] dq_in, dq_out;
  logic [1:0]  dq_oe;
  logic [RB-1:0] rfsh_row;
  logic [3:0]  timing_err;

  int n_chk, n_fail;
  bit done;

  logic [15:0] sh [NW];
  logic [1:0]  sv [NW];
  logic [8:0]  wr_r [NRND];
  logic [8:0]  wr_c [NRND];

  dram_pin_responder u_dram_pin_responder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .rfsh_row(rfsh_row), .timing_err(timing_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int widx(logic [8:0] r, logic [8:0] c);
    return int'({r[RB-1:0], c[CB-1:0]});
  endfunction

  function automatic logic [15:0] lmask(logic [1:0] ln);
    return {{8{ln[1]}}, {8{ln[0]}}};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pins();
    ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic ras_open(logic [8:0] r);
    addr = r; ras_n = 0; cyc(3);
  endtask

  task automatic ras_close();
    idle_pins(); cyc(4);
  endtask

  task automatic cas_wr(logic [8:0] c, logic [15:0] d, logic [1:0] ln);
    addr = c; dq_in = d; we_n = 0; oe_n = 1;
    lcas_n = ~ln[0]; ucas_n = ~ln[1];
    cyc(2);
    lcas_n = 1; ucas_n = 1; cyc(1);
    we_n = 1; cyc(1);
  endtask

  task automatic cas_rd(logic [8:0] c, logic [1:0] ln, logic [15:0] exp, string tag);
    addr = c; we_n = 1; oe_n = 0;
    lcas_n = ~ln[0]; ucas_n = ~ln[1];
    cyc(3);
    chk(tag, dq_oe, ln);
    chk(tag, dq_out & lmask(ln), exp & lmask(ln));
    lcas_n = 1; ucas_n = 1; cyc(2);
  endtask

  task automatic do_write(logic [8:0] r, logic [8:0] c, logic [15:0] d, logic [1:0] ln);
    int k;
    ras_open(r); cas_wr(c, d, ln); ras_close();
    k = widx(r, c);
    if (ln[0]) sh[k][7:0]  = d[7:0];
    if (ln[1]) sh[k][15:8] = d[15:8];
    sv[k] = sv[k] | ln;
  endtask

  task automatic do_read(logic [8:0] r, logic [8:0] c, logic [1:0] ln, string tag);
    ras_open(r); cas_rd(c, ln, sh[widx(r, c)], tag); ras_close();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7391));
    for (int i = 0; i < NW; i++) begin sh[i] = '0; sv[i] = '0; end
    rst_n = 0; idle_pins(); addr = '0; dq_in = '0;
    cyc(3);
    rst_n = 1;
    cyc(6);

    // R11 reset state
    chk("R11 dq_oe", dq_oe, 0);
    chk("R11 rfsh_row", rfsh_row, 0);
    chk("R11 timing_err", timing_err, 0);
    // R1 standby
    chk("R1 standby", dq_oe, 0);

    // R3 byte writes, other lane kept; R2 per-lane reads
    do_write(9'd2, 9'd5, 16'hA1B2, 2'b11);
    do_write(9'd2, 9'd5, 16'hFFCC, 2'b10);
    do_read(9'd2, 9'd5, 2'b11, "R3 upper only");
    chk("R3 merged word", sh[widx(9'd2, 9'd5)], 16'hFFB2);
    do_read(9'd2, 9'd5, 2'b01, "R2 low lane alone");
    do_read(9'd2, 9'd5, 2'b10, "R2 high lane alone");

    // R12 page mode: two columns under one row strobe
    ras_open(9'd6);
    cas_wr(9'd1, 16'h1357, 2'b11);
    cas_wr(9'd9, 16'h2468, 2'b11);
    sh[widx(9'd6, 9'd1)] = 16'h1357; sv[widx(9'd6, 9'd1)] = 2'b11;
    sh[widx(9'd6, 9'd9)] = 16'h2468; sv[widx(9'd6, 9'd9)] = 2'b11;
    cas_rd(9'd1, 2'b11, 16'h1357, "R12 page col a");
    cas_rd(9'd9, 2'b11, 16'h2468, "R12 page col b");
    ras_close();
    chk("R1 after close", dq_oe, 0);

    // R5 hold after strobe rise; R6 turn-off by output enable
    ras_open(9'd6);
    cas_rd(9'd9, 2'b01, 16'h2468, "R5 setup");
    chk("R5 lane held", dq_oe, 2'b01);
    chk("R5 data held", dq_out[7:0], 8'h68);
    oe_n = 1; cyc(2);
    chk("R6 oe off", dq_oe, 0);
    // R6 turn-off by write enable
    cas_rd(9'd1, 2'b11, 16'h1357, "R6 setup we");
    we_n = 0; cyc(2);
    chk("R6 we off", dq_oe, 0);
    we_n = 1; cyc(1);
    // R6 turn-off by row and column strobes high
    cas_rd(9'd1, 2'b10, 16'h1357, "R6 setup ras");
    chk("R5 held before ras rise", dq_oe, 2'b10);
    ras_n = 1; cyc(2);
    chk("R6 ras off", dq_oe, 0);
    ras_close();

    // R4 both strobes low, no command
    ras_open(9'd2);
    addr = 9'd5; dq_in = 16'h0000; we_n = 1; oe_n = 1; lcas_n = 0; ucas_n = 0;
    cyc(3);
    chk("R4 no drive", dq_oe, 0);
    lcas_n = 1; ucas_n = 1; cyc(2);
    ras_close();
    do_read(9'd2, 9'd5, 2'b11, "R4 no write");

    // R7 row-only refresh
    addr = 9'd2; dq_in = 16'h0000; we_n = 0; ras_n = 0; cyc(6);
    chk("R7 no drive", dq_oe, 0);
    ras_close();
    do_read(9'd2, 9'd5, 2'b11, "R7 data intact");

    // R8 strobe-before-row refresh, twice, with write-like pins
    for (int k = 1; k <= 2; k++) begin
      lcas_n = 0; we_n = 0; oe_n = 1; dq_in = 16'hDEAD; addr = 9'd2; cyc(2);
      ras_n = 0; cyc(5);
      chk("R8 no drive", dq_oe, 0);
      chk("R8 counter", rfsh_row, k);
      ras_close();
    end
    do_read(9'd2, 9'd5, 2'b11, "R8 no access");

    // R9 upper address bits ignored
    do_write(9'h1A3, 9'h0F7, 16'h5A5A, 2'b11);
    do_read(9'h003, 9'h007, 2'b11, "R9 alias read");
    chk("R9 alias index", widx(9'h1A3, 9'h0F7), widx(9'h003, 9'h007));

    // random writes then reads, R2 and R3
    for (int i = 0; i < NRND; i++) begin
      logic [8:0] r, c;
      logic [1:0] ln;
      r = 9'($urandom); c = 9'($urandom); ln = 2'($urandom_range(1, 3));
      wr_r[i] = r; wr_c[i] = c;
      do_write(r, c, 16'($urandom), ln);
    end
    for (int i = 0; i < 30; i++) begin
      int k;
      k = $urandom_range(0, NRND - 1);
      do_read(wr_r[k], wr_c[k], sv[widx(wr_r[k], wr_c[k])], "R2 random read");
    end

    // R10 legal so far, then each violation in turn
    chk("R10 clean", timing_err, 4'b0000);
    ras_n = 0; cyc(2); ras_n = 1; cyc(4);
    chk("R10 short row low", timing_err, 4'b0001);
    ras_n = 0; cyc(5); ras_n = 1; cyc(1); ras_n = 0; cyc(5); ras_n = 1; cyc(4);
    chk("R10 short row high", timing_err, 4'b0011);
    ras_n = 0; cyc(1); lcas_n = 0; ucas_n = 0; cyc(4); ras_close();
    chk("R10 short row-to-col", timing_err, 4'b1011);
    ras_n = 0; cyc(3); lcas_n = 0; ucas_n = 0; cyc(2);
    lcas_n = 1; ucas_n = 1; cyc(1); lcas_n = 0; ucas_n = 0; cyc(2);
    ras_close();
    chk("R10 short col precharge", timing_err, 4'b1111);

    finish_run();
  end
endmodule